// File: doc/BRIEF.md
# Package Idle-State Coordinator

This block decides idle depths for a cluster of cores that share a cache, a PLL, a clock tree and a voltage plane. A core asks to go idle with a one-cycle request. The coordinator picks a depth for it and holds that core's granted depth until a wake request arrives. Depth 0 means running, and idle levels 1 to NLVL get deeper as the number grows. A deeper level saves more power but takes longer to leave.

Depth is picked in one of two ways. In step-wise mode, a per-core history moves one level at a time. It moves deeper after an idle period that outlasted the current level's residency, and shallower after an early wake. In budget mode, the selector takes the deepest level whose programmed exit latency fits a latency limit and whose target residency fits the core's expected sleep time.

When every core in the group sits idle at the same depth, a package state machine powers down the shared resources in order. Any wake undoes this in the reverse order: voltage, then PLL, then clocks and cache. Only after that does the waking core get released.

Per-core states are CS_RUN, CS_IDLE and CS_WAKING. The transitions are: run to idle on a request with no wake; idle to waking on a wake; waking to run once the package is active. Package states are PS_ACTIVE, PS_GATE_CLK, PS_GATE_PLL, PS_PKG_IDLE, PS_RESTORE_VDD and PS_RESTORE_PLL. They enter, abort or restore as listed in R5, R6 and R9.

Top module: `pidle_coord`

## Requirements
- R1: While rst_n is low, every core_depth is 0, pkg_idle is 0 and all four off_* outputs are 0. Each off_* output is 1 when its resource is shut down.
- R2: A running core that sees idle_req high and wake_req low at a clock edge shows its selected idle depth (1..NLVL) on core_depth after that edge. A running core shows depth 0.
- R3: In step-wise mode (sel_budget=0), the depth taken is the core's history value. The history starts at 1 after reset. It is updated at every wake from idle, based on the number of idle cycles counted since entry (saturating at the counter width). If that count exceeds the current level's residency, the history becomes the current level plus one, capped at NLVL. If the count is below the residency, it becomes the current level minus one, floored at 1. If they are equal, it becomes the current level.
- R4: In budget mode (sel_budget=1), the depth taken is the deepest level d with exit_lat[d-1] <= lat_limit and min_res[d-1] <= that core's exp_sleep. If no level qualifies, level 1 is taken.
- R5: The package leaves PS_ACTIVE only when all cores are idle at one common depth. It then shuts down clocks and cache, then the PLL one cycle later, then the voltage one cycle later. pkg_idle is 1 only in that last state.
- R6: A wake request during package idle restores the voltage first, then the PLL one cycle later, then clocks and cache one cycle later. Each step lasts one cycle.
- R7: A woken core keeps showing its idle depth until the package is active, and shows 0 from the cycle after that.
- R8: Cores that did not wake keep their granted idle depth after the package returns to active.
- R9: A wake that arrives while only clocks are gated returns straight to active. A wake that arrives while the PLL is gated restores the PLL and then the clocks.
- R10: A running core that sees idle_req and wake_req together stays running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | NCORES | Per-core idle request |
| wake_req | input | NCORES | Per-core wake request |
| sel_budget | input | 1 | 1 selects budget mode, 0 selects step-wise mode |
| lat_limit | input | LW | Exit-latency limit for budget mode |
| exp_sleep | input | NCORES*TW | Per-core expected sleep time |
| exit_lat | input | NLVL*LW | Exit latency per idle level; entry d-1 is level d |
| min_res | input | NLVL*TW | Target residency per idle level; entry d-1 is level d |
| core_depth | output | NCORES*DW | Granted depth per core, 0 when running |
| pkg_idle | output | 1 | Package in its deepest shared-off state |
| off_cache | output | 1 | Shared cache shut down |
| off_pll | output | 1 | PLL shut down |
| off_clk | output | 1 | Clock tree shut down |
| off_vdd | output | 1 | Voltage plane shut down |

## Verification
The hardest case to reach is a wake that lands partway through package entry. Every core must already be idle at one shared depth, and the wake must arrive exactly one edge after the last core settled. The stimulus gives all cores equal expected sleep in budget mode so that they pick the same level. It releases all idle requests together and pulses one wake on the very next cycle, which catches the package in its clock-gated step. The step-wise history is driven into saturation and back by alternating long and very short idle periods on a single core.

// File: rtl/pidle_pkg.sv
package pidle_pkg;
    typedef enum logic [1:0] {
        CS_RUN,
        CS_IDLE,
        CS_WAKING
    } core_st_e;

    typedef enum logic [2:0] {
        PS_ACTIVE,
        PS_GATE_CLK,
        PS_GATE_PLL,
        PS_PKG_IDLE,
        PS_RESTORE_VDD,
        PS_RESTORE_PLL
    } pkg_st_e;

    typedef struct packed {
        logic cache;
        logic pll;
        logic clk;
        logic vdd;
    } gate_t;
endpackage

// File: rtl/pidle_depth_select.sv
module pidle_depth_select #(
    parameter int NLVL = 3,
    parameter int LW   = 8,
    parameter int TW   = 8,
    parameter int DW   = $clog2(NLVL + 1)
) (
    input  logic                     use_budget,
    input  logic [DW-1:0]            step_depth,
    input  logic [TW-1:0]            sleep_est,
    input  logic [LW-1:0]            lat_max,
    input  logic [NLVL-1:0][LW-1:0]  lat_tab,
    input  logic [NLVL-1:0][TW-1:0]  res_tab,
    output logic [DW-1:0]            pick
);
    logic [NLVL-1:0] fits;
    logic [DW-1:0]   deepest;

    for (genvar g = 0; g < NLVL; g++) begin : g_fit
        assign fits[g] = (lat_tab[g] <= lat_max) && (res_tab[g] <= sleep_est);
    end

    always_comb begin
        deepest = DW'(1);
        for (int d = 0; d < NLVL; d++) begin
            if (fits[d]) deepest = DW'(d + 1);
        end
    end

    assign pick = use_budget ? deepest : step_depth;
endmodule

// File: rtl/pidle_core_ctl.sv
module pidle_core_ctl
    import pidle_pkg::*;
#(
    parameter int NLVL = 3,
    parameter int TW   = 8,
    parameter int DW   = $clog2(NLVL + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     idle_req,
    input  logic                     wake_req,
    input  logic                     pkg_active,
    input  logic [DW-1:0]            pick,
    input  logic [NLVL-1:0][TW-1:0]  res_tab,
    output logic [DW-1:0]            depth_o,
    output logic                     is_idle,
    output logic                     is_waking,
    output logic [DW-1:0]            step_o
);
    localparam logic [DW-1:0] DMAX = DW'(NLVL);
    localparam logic [DW-1:0] DMIN = DW'(1);
    localparam logic [TW-1:0] CMAX = '1;

    core_st_e        state_q, state_d;
    logic [DW-1:0]   depth_q, step_q, res_idx;
    logic [TW-1:0]   cnt_q, res_cur;

    assign res_idx = (depth_q == '0) ? '0 : depth_q - DMIN;
    assign res_cur = res_tab[res_idx];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_RUN:    if (idle_req && !wake_req) state_d = CS_IDLE;
            CS_IDLE:   if (wake_req)              state_d = CS_WAKING;
            CS_WAKING: if (pkg_active)            state_d = CS_RUN;
            default:                              state_d = CS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
            cnt_q   <= '0;
            step_q  <= DMIN;
        end else begin
            if (state_q == CS_RUN && state_d == CS_IDLE) begin
                depth_q <= pick;
                cnt_q   <= '0;
            end else if (state_q == CS_IDLE && state_d == CS_IDLE && cnt_q != CMAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == CS_IDLE && state_d == CS_WAKING) begin
                if (cnt_q > res_cur)
                    step_q <= (depth_q == DMAX) ? DMAX : depth_q + 1'b1;
                else if (cnt_q < res_cur)
                    step_q <= (depth_q == DMIN) ? DMIN : depth_q - 1'b1;
                else
                    step_q <= depth_q;
            end
        end
    end

    always_comb begin
        depth_o   = (state_q == CS_RUN) ? '0 : depth_q;
        is_idle   = (state_q == CS_IDLE);
        is_waking = (state_q == CS_WAKING);
        step_o    = step_q;
    end

    assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_RUN && idle_req && !wake_req) |=> (depth_o != '0));

    assert_run_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_RUN && wake_req) |=> (depth_o == '0));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(depth_o) != '0 && depth_o == '0) |-> $past(pkg_active));

    assert_step_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q >= DMIN) && (step_q <= DMAX));
endmodule

// File: rtl/pidle_pkg_ctl.sv
module pidle_pkg_ctl
    import pidle_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  all_same,
    input  logic  any_wake,
    output gate_t off,
    output logic  pkg_idle,
    output logic  pkg_active
);
    pkg_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_ACTIVE:      if (all_same && !any_wake) state_d = PS_GATE_CLK;
            PS_GATE_CLK:    state_d = (any_wake || !all_same) ? PS_ACTIVE : PS_GATE_PLL;
            PS_GATE_PLL:    state_d = any_wake ? PS_RESTORE_PLL : PS_PKG_IDLE;
            PS_PKG_IDLE:    if (any_wake) state_d = PS_RESTORE_VDD;
            PS_RESTORE_VDD: state_d = PS_RESTORE_PLL;
            PS_RESTORE_PLL: state_d = PS_ACTIVE;
            default:        state_d = PS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        off        = '0;
        pkg_idle   = 1'b0;
        pkg_active = 1'b0;
        unique case (state_q)
            PS_ACTIVE:      pkg_active = 1'b1;
            PS_GATE_CLK:    begin off.clk = 1'b1; off.cache = 1'b1; end
            PS_GATE_PLL:    begin off.clk = 1'b1; off.cache = 1'b1; off.pll = 1'b1; end
            PS_PKG_IDLE:    begin off = '1; pkg_idle = 1'b1; end
            PS_RESTORE_VDD: begin off.clk = 1'b1; off.cache = 1'b1; off.pll = 1'b1; end
            PS_RESTORE_PLL: begin off.clk = 1'b1; off.cache = 1'b1; end
            default:        pkg_active = 1'b1;
        endcase
    end

    assert_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off.clk) |-> $past(all_same));

    assert_vdd_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(off.vdd) |=> $fell(off.pll));

    assert_pll_then_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(off.pll) |=> (!off.clk && !off.cache));

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_GATE_CLK && any_wake) |=> (!off.clk && !off.pll));
endmodule

// File: rtl/pidle_coord.sv
module pidle_coord
    import pidle_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NLVL   = 3,
    parameter int LW     = 8,
    parameter int TW     = 8,
    parameter int DW     = $clog2(NLVL + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCORES-1:0]          idle_req,
    input  logic [NCORES-1:0]          wake_req,
    input  logic                       sel_budget,
    input  logic [LW-1:0]              lat_limit,
    input  logic [NCORES-1:0][TW-1:0]  exp_sleep,
    input  logic [NLVL-1:0][LW-1:0]    exit_lat,
    input  logic [NLVL-1:0][TW-1:0]    min_res,
    output logic [NCORES-1:0][DW-1:0]  core_depth,
    output logic                       pkg_idle,
    output logic                       off_cache,
    output logic                       off_pll,
    output logic                       off_clk,
    output logic                       off_vdd
);
    logic [NCORES-1:0]         idle_v, wake_v;
    logic [NCORES-1:0][DW-1:0] pick_v, step_v;
    logic                      all_same, any_wake, pkg_active;
    gate_t                     off;

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        pidle_depth_select #(.NLVL(NLVL), .LW(LW), .TW(TW), .DW(DW)) u_sel (
            .use_budget (sel_budget),
            .step_depth (step_v[c]),
            .sleep_est  (exp_sleep[c]),
            .lat_max    (lat_limit),
            .lat_tab    (exit_lat),
            .res_tab    (min_res),
            .pick       (pick_v[c])
        );
        pidle_core_ctl #(.NLVL(NLVL), .TW(TW), .DW(DW)) u_core (
            .clk        (clk),
            .rst_n      (rst_n),
            .idle_req   (idle_req[c]),
            .wake_req   (wake_req[c]),
            .pkg_active (pkg_active),
            .pick       (pick_v[c]),
            .res_tab    (min_res),
            .depth_o    (core_depth[c]),
            .is_idle    (idle_v[c]),
            .is_waking  (wake_v[c]),
            .step_o     (step_v[c])
        );
    end

    always_comb begin
        all_same = 1'b1;
        for (int i = 0; i < NCORES; i++) begin
            if (!idle_v[i] || core_depth[i] != core_depth[0]) all_same = 1'b0;
        end
    end

    assign any_wake = |wake_v;

    pidle_pkg_ctl u_pkg (
        .clk        (clk),
        .rst_n      (rst_n),
        .all_same   (all_same),
        .any_wake   (any_wake),
        .off        (off),
        .pkg_idle   (pkg_idle),
        .pkg_active (pkg_active)
    );

    assign off_cache = off.cache;
    assign off_pll   = off.pll;
    assign off_clk   = off.clk;
    assign off_vdd   = off.vdd;
endmodule

// File: tb/tb_pidle_coord.sv
module tb_pidle_coord;
    localparam int NC = 4, NL = 3, LW = 8, TW = 8, DW = 2;

    logic clk = 0, rst_n = 0;
    logic [NC-1:0] idle_req = '0, wake_req = '0;
    logic sel_budget = 0;
    logic [LW-1:0] lat_limit = 0;
    logic [NC-1:0][TW-1:0] exp_sleep = '0;
    logic [NL-1:0][LW-1:0] exit_lat;
    logic [NL-1:0][TW-1:0] min_res;
    logic [NC-1:0][DW-1:0] core_depth;
    logic pkg_idle, off_cache, off_pll, off_clk, off_vdd;

    int errors = 0, checks = 0, cyc = 0;
    int m_st[NC], m_dep[NC], m_cnt[NC], m_step[NC];
    int m_ps = 0, same, wk, nps, r;
    int lat_t[NL] = '{2, 10, 40};
    int res_t[NL] = '{4, 8, 16};

    assign exit_lat = {8'd40, 8'd10, 8'd2};
    assign min_res  = {8'd16, 8'd8, 8'd4};

    pidle_coord dut (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .wake_req(wake_req),
        .sel_budget(sel_budget), .lat_limit(lat_limit), .exp_sleep(exp_sleep),
        .exit_lat(exit_lat), .min_res(min_res), .core_depth(core_depth),
        .pkg_idle(pkg_idle), .off_cache(off_cache), .off_pll(off_pll),
        .off_clk(off_clk), .off_vdd(off_vdd)
    );

    always #10 clk = ~clk;

    function automatic int pick(int i);
        int b;
        if (!sel_budget) return m_step[i];
        b = 1;
        for (int d = 1; d <= NL; d++)
            if (lat_t[d-1] <= int'(lat_limit) && res_t[d-1] <= int'(exp_sleep[i])) b = d;
        return b;
    endfunction

    function automatic int gates(int ps); // {cache,pll,clk,vdd}
        case (ps)
            1: return 4'b1010;
            2: return 4'b1110;
            3: return 4'b1111;
            4: return 4'b1110;
            5: return 4'b1010;
            default: return 4'b0000;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) begin
                m_st[i] = 0; m_dep[i] = 0; m_cnt[i] = 0; m_step[i] = 1;
            end
            m_ps = 0;
        end else begin
            same = 1; wk = 0;
            for (int i = 0; i < NC; i++) begin
                if (m_st[i] != 1 || m_dep[i] != m_dep[0]) same = 0;
                if (m_st[i] == 2) wk = 1;
            end
            nps = m_ps;
            case (m_ps)
                0: if (same && !wk) nps = 1;
                1: nps = (wk || !same) ? 0 : 2;
                2: nps = wk ? 5 : 3;
                3: if (wk) nps = 4;
                4: nps = 5;
                default: nps = 0;
            endcase
            for (int i = 0; i < NC; i++) begin
                case (m_st[i])
                    0: if (idle_req[i] && !wake_req[i]) begin
                           m_dep[i] = pick(i); m_st[i] = 1; m_cnt[i] = 0;
                       end
                    1: if (wake_req[i]) begin
                           m_st[i] = 2; r = res_t[m_dep[i]-1];
                           if (m_cnt[i] > r) m_step[i] = (m_dep[i] == NL) ? NL : m_dep[i] + 1;
                           else if (m_cnt[i] < r) m_step[i] = (m_dep[i] == 1) ? 1 : m_dep[i] - 1;
                           else m_step[i] = m_dep[i];
                       end else if (m_cnt[i] < 255) m_cnt[i]++;
                    default: if (m_ps == 0) m_st[i] = 0;
                endcase
            end
            m_ps = nps;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        for (int i = 0; i < NC; i++)
            chk($sformatf("R2/R3/R4/R7/R8 depth core%0d", i), int'(core_depth[i]),
                (m_st[i] == 0) ? 0 : m_dep[i]);
        chk("R5/R6/R9 gates", int'({off_cache, off_pll, off_clk, off_vdd}), gates(m_ps));
        chk("R5 pkg_idle", int'(pkg_idle), (m_ps == 3) ? 1 : 0);
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(int n); repeat (n) @(negedge clk); endtask
    task automatic go_idle(logic [NC-1:0] m); idle_req = m; step(1); idle_req = '0; endtask
    task automatic wake(logic [NC-1:0] m); wake_req = m; step(1); wake_req = '0; endtask

    initial begin
        step(3);
        chk("R1 depth", int'(core_depth), 0);
        chk("R1 gates", int'({off_cache, off_pll, off_clk, off_vdd}), 0);
        rst_n = 1; step(2);

        // R3 step-wise walk on core 0
        go_idle(4'b0001); chk("R3 first", int'(core_depth[0]), 1);
        step(20); wake(4'b0001); step(3);
        go_idle(4'b0001); chk("R3 deeper", int'(core_depth[0]), 2);
        step(20); wake(4'b0001); step(3);
        go_idle(4'b0001); chk("R3 deepest", int'(core_depth[0]), 3);
        step(20); wake(4'b0001); step(3);
        go_idle(4'b0001); chk("R3 cap", int'(core_depth[0]), 3);
        step(2); wake(4'b0001); step(3);
        go_idle(4'b0001); chk("R3 shallower", int'(core_depth[0]), 2);
        step(3); wake(4'b0001); step(3);

        // R4 budget mode on core 1
        sel_budget = 1; lat_limit = 20; exp_sleep[1] = 20;
        go_idle(4'b0010); chk("R4 latency bound", int'(core_depth[1]), 2);
        wake(4'b0010); step(4);
        lat_limit = 50;
        go_idle(4'b0010); chk("R4 deepest fit", int'(core_depth[1]), 3);
        wake(4'b0010); step(4);
        exp_sleep[1] = 5;
        go_idle(4'b0010); chk("R4 sleep bound", int'(core_depth[1]), 1);
        wake(4'b0010); step(4);
        exp_sleep[1] = 2;
        go_idle(4'b0010); chk("R4 none fits", int'(core_depth[1]), 1);
        wake(4'b0010); step(4);

        // R5 / R6 / R7 / R8 full package cycle
        exp_sleep = {8'd20, 8'd20, 8'd20, 8'd20};
        go_idle(4'b1111); step(5);
        chk("R5 pkg idle", int'(pkg_idle), 1);
        chk("R5 vdd off", int'(off_vdd), 1);
        wake(4'b0100);
        step(1); chk("R6 vdd on", int'(off_vdd), 0); chk("R6 pll still off", int'(off_pll), 1);
        step(1); chk("R6 pll on", int'(off_pll), 0); chk("R6 clk still off", int'(off_clk), 1);
        chk("R7 held", int'(core_depth[2]), 3);
        step(1); chk("R6 clk on", int'(off_clk), 0); chk("R7 held at active", int'(core_depth[2]), 3);
        step(1); chk("R7 released", int'(core_depth[2]), 0);
        chk("R8 core0 kept", int'(core_depth[0]), 3);
        chk("R8 core3 kept", int'(core_depth[3]), 3);
        wake(4'b1011); step(4);

        // R9 abort during entry
        go_idle(4'b1111);
        wake(4'b0001);
        chk("R9 clk gated", int'(off_clk), 1);
        step(1); chk("R9 back active clk", int'(off_clk), 0); chk("R9 pll", int'(off_pll), 0);
        wake(4'b1110); step(4);

        // R5 mismatched depths block entry
        exp_sleep[0] = 5;
        go_idle(4'b1111); step(6);
        chk("R5 no entry", int'(pkg_idle), 0);
        chk("R5 clk running", int'(off_clk), 0);
        wake(4'b1111); step(4);

        // R10 simultaneous idle and wake
        idle_req = 4'b0010; wake_req = 4'b0010; step(1);
        idle_req = '0; wake_req = '0;
        chk("R10 stays running", int'(core_depth[1]), 0);
        step(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule